// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register bank that sits in front of an Ethernet DMA engine pair. A CPU reaches it over a plain 32-bit bus with a byte address, a write strobe and a read strobe. The low two address bits are dropped to form a word index, and that index selects one register. The bank holds the DMA setup registers: bus mode, operation control and interrupt enable. It holds the two descriptor-list bases and the two current-descriptor pointers that the engines walk. It holds a sticky event status word. It also carries a fixed version word and the two words of the station address.

The engines talk to the bank through side ports. Status-set pulses raise event bits, and these bits stay set until software writes a one to them. Pointer-load pulses move the current-descriptor pointers forward. A write to either poll-demand word does not store anything. Instead it produces a one-cycle strobe toward the matching engine. A single level interrupt is high while any status bit is set whose enable bit is also set.

The block has no sequencing state. Every register updates in the cycle of the bus write or the engine pulse that targets it. Read data is combinational.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, status, interrupt enable, control, bus mode, both bases and both current pointers read 0 and `irq` is 0. The station-address high word (word 0x10) holds bytes 5 and 4 of `STATION_MAC` in bits 15:8 and 7:0. The low word (word 0x11) holds bytes 3 down to 0, with byte 0 in bits 7:0.
- R2: Word index 8 always reads 0x00001012. A write to it changes nothing.
- R3: A write to status (word 0x3C5) clears every status bit whose written data bit is 1. All other status bits keep their value.
- R4: Each bit of `hw_status_set` sets that status bit at the next edge, and the bit stays set until software clears it. When a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to bus mode (word 0x3C0) stores the data with bit 0 forced to 0.
- R6: A write to the receive base (word 0x3C3) also loads the current receive pointer (word 0x3D3, output `cur_rx_desc`). A write to the transmit base (word 0x3C4) also loads the current transmit pointer (word 0x3D2, output `cur_tx_desc`).
- R7: A write to word 0x3C1 drives `tx_poll` high for exactly the one cycle after the write edge, and the same holds for word 0x3C2 and `rx_poll`. Both words read 0.
- R8: `irq` is 1 exactly when the AND of status and interrupt enable (word 0x3C7) is nonzero, from the cycle after the write or set pulse that changes either of them.
- R9: Control is word 0x3C6. Control bit 1 drives `rx_enable` and control bit 13 drives `tx_enable`.
- R10: Reads of any word index that is not implemented return 0. Writes to such an index change no register and raise no strobe.
- R11: A pointer-load pulse loads the matching current pointer with the value on its port. In the same cycle, a software write to that pointer (directly or through its base) takes priority.
- R12: `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| hw_status_set | input | 32 | Per-bit status set pulses from the engines |
| tx_ptr_load | input | 1 | Transmit engine pointer update |
| tx_ptr_value | input | 32 | New transmit current pointer |
| rx_ptr_load | input | 1 | Receive engine pointer update |
| rx_ptr_value | input | 32 | New receive current pointer |
| cur_tx_desc | output | 32 | Current transmit descriptor pointer |
| cur_rx_desc | output | 32 | Current receive descriptor pointer |
| tx_enable | output | 1 | Transmit engine enable |
| rx_enable | output | 1 | Receive engine enable |
| tx_poll | output | 1 | One-cycle transmit poll strobe |
| rx_poll | output | 1 | One-cycle receive poll strobe |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide in one cycle. The first is a status write-one-to-clear meeting an engine set pulse on the same bit. The second is a software base or pointer write meeting an engine pointer load. Directed steps drive both inputs at the same edge. The random phase also overlaps engine pulses with bus writes many times, on the same address pool. The bench model applies the clear first, then the set, and lets the software pointer write override the engine load. After every step it compares the status read-back, both pointers and `irq` against that model.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int unsigned IDX_VERSION  = 10'h008;
    localparam int unsigned IDX_STA_HI   = 10'h010;
    localparam int unsigned IDX_STA_LO   = 10'h011;
    localparam int unsigned IDX_BUS_MODE = 10'h3C0;
    localparam int unsigned IDX_TX_POLL  = 10'h3C1;
    localparam int unsigned IDX_RX_POLL  = 10'h3C2;
    localparam int unsigned IDX_RX_BASE  = 10'h3C3;
    localparam int unsigned IDX_TX_BASE  = 10'h3C4;
    localparam int unsigned IDX_STATUS   = 10'h3C5;
    localparam int unsigned IDX_CONTROL  = 10'h3C6;
    localparam int unsigned IDX_INT_EN   = 10'h3C7;
    localparam int unsigned IDX_CUR_TX   = 10'h3D2;
    localparam int unsigned IDX_CUR_RX   = 10'h3D3;

    localparam int unsigned CTRL_RX_BIT  = 1;
    localparam int unsigned CTRL_TX_BIT  = 13;

    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned CH_TX    = 0;
    localparam int unsigned CH_RX    = 1;

    typedef struct packed {
        logic version;
        logic sta_hi;
        logic sta_lo;
        logic bus_mode;
        logic tx_poll;
        logic rx_poll;
        logic rx_base;
        logic tx_base;
        logic status;
        logic control;
        logic int_en;
        logic cur_tx;
        logic cur_rx;
    } csr_sel_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_t          sel,
    output logic              hit
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        sel = '0;
        unique case (widx)
            WIDX_W'(IDX_VERSION):  sel.version  = 1'b1;
            WIDX_W'(IDX_STA_HI):   sel.sta_hi   = 1'b1;
            WIDX_W'(IDX_STA_LO):   sel.sta_lo   = 1'b1;
            WIDX_W'(IDX_BUS_MODE): sel.bus_mode = 1'b1;
            WIDX_W'(IDX_TX_POLL):  sel.tx_poll  = 1'b1;
            WIDX_W'(IDX_RX_POLL):  sel.rx_poll  = 1'b1;
            WIDX_W'(IDX_RX_BASE):  sel.rx_base  = 1'b1;
            WIDX_W'(IDX_TX_BASE):  sel.tx_base  = 1'b1;
            WIDX_W'(IDX_STATUS):   sel.status   = 1'b1;
            WIDX_W'(IDX_CONTROL):  sel.control  = 1'b1;
            WIDX_W'(IDX_INT_EN):   sel.int_en   = 1'b1;
            WIDX_W'(IDX_CUR_TX):   sel.cur_tx   = 1'b1;
            WIDX_W'(IDX_CUR_RX):   sel.cur_rx   = 1'b1;
            default:               sel          = '0;
        endcase
    end

    assign hit = |sel;

    // at most one register selected for any address
    always_comb begin
        a_r10_sel_onehot: assert ($onehot0(sel));
    end

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];

endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (clr_en) begin
            nxt = nxt & ~clr_mask;
        end
        nxt = nxt | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    a_r4_set_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((q & $past(set_mask)) == $past(set_mask)));

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(clr_mask) & ~$past(set_mask)) == '0));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && (set_mask == '0)) |=> (q == $past(q)));

endmodule

// File: rtl/csr_ptr_pair.sv
module csr_ptr_pair #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         base_we,
    input  logic         cur_we,
    input  logic [W-1:0] wdata,
    input  logic         eng_load,
    input  logic [W-1:0] eng_value,
    output logic [W-1:0] base_q,
    output logic [W-1:0] cur_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we) begin
                base_q <= wdata;
            end
            if (base_we || cur_we) begin
                cur_q <= wdata;
            end else if (eng_load) begin
                cur_q <= eng_value;
            end
        end
    end

    a_r6_base_reload: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (cur_q == base_q));

    a_r11_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_we || cur_we) && eng_load) |=> (cur_q == $past(wdata)));

    a_r11_eng_load: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load && !base_we && !cur_we) |=> (cur_q == $past(eng_value)));

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter logic [47:0] STATION_MAC = 48'hA1B2_C3D4_E5F6,
    parameter logic [31:0] VERSION_ID  = 32'h0000_1012
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       hw_status_set,
    input  logic              tx_ptr_load,
    input  logic [31:0]       tx_ptr_value,
    input  logic              rx_ptr_load,
    input  logic [31:0]       rx_ptr_value,
    output logic [31:0]       cur_tx_desc,
    output logic [31:0]       cur_rx_desc,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              tx_poll,
    output logic              rx_poll,
    output logic              irq
);
    localparam int unsigned DW = 32;
    localparam logic [DW-1:0] STA_HI_RST = {16'h0000, STATION_MAC[47:32]};
    localparam logic [DW-1:0] STA_LO_RST = STATION_MAC[31:0];

    csr_sel_t sel;
    logic     hit;

    csr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    // status word
    logic [DW-1:0] status_q;

    csr_status_reg #(.W(DW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr && sel.status),
        .clr_mask (bus_wdata),
        .set_mask (hw_status_set),
        .q        (status_q)
    );

    // base / current pointer pairs, one per channel
    logic [NUM_CHAN-1:0]         ch_base_we;
    logic [NUM_CHAN-1:0]         ch_cur_we;
    logic [NUM_CHAN-1:0]         ch_eng_load;
    logic [NUM_CHAN-1:0][DW-1:0] ch_eng_value;
    logic [NUM_CHAN-1:0][DW-1:0] ch_base_q;
    logic [NUM_CHAN-1:0][DW-1:0] ch_cur_q;

    assign ch_base_we[CH_TX]   = bus_wr && sel.tx_base;
    assign ch_base_we[CH_RX]   = bus_wr && sel.rx_base;
    assign ch_cur_we[CH_TX]    = bus_wr && sel.cur_tx;
    assign ch_cur_we[CH_RX]    = bus_wr && sel.cur_rx;
    assign ch_eng_load[CH_TX]  = tx_ptr_load;
    assign ch_eng_load[CH_RX]  = rx_ptr_load;
    assign ch_eng_value[CH_TX] = tx_ptr_value;
    assign ch_eng_value[CH_RX] = rx_ptr_value;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        csr_ptr_pair #(.W(DW)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_we   (ch_base_we[c]),
            .cur_we    (ch_cur_we[c]),
            .wdata     (bus_wdata),
            .eng_load  (ch_eng_load[c]),
            .eng_value (ch_eng_value[c]),
            .base_q    (ch_base_q[c]),
            .cur_q     (ch_cur_q[c])
        );
    end

    assign cur_tx_desc = ch_cur_q[CH_TX];
    assign cur_rx_desc = ch_cur_q[CH_RX];

    // plain storage registers and poll strobes
    logic [DW-1:0] bus_mode_q;
    logic [DW-1:0] control_q;
    logic [DW-1:0] int_en_q;
    logic [DW-1:0] sta_hi_q;
    logic [DW-1:0] sta_lo_q;
    logic          tx_poll_q;
    logic          rx_poll_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_mode_q <= '0;
            control_q  <= '0;
            int_en_q   <= '0;
            sta_hi_q   <= STA_HI_RST;
            sta_lo_q   <= STA_LO_RST;
            tx_poll_q  <= 1'b0;
            rx_poll_q  <= 1'b0;
        end else begin
            tx_poll_q <= bus_wr && sel.tx_poll;
            rx_poll_q <= bus_wr && sel.rx_poll;
            if (bus_wr) begin
                if (sel.bus_mode) bus_mode_q <= {bus_wdata[DW-1:1], 1'b0};
                if (sel.control)  control_q  <= bus_wdata;
                if (sel.int_en)   int_en_q   <= bus_wdata;
                if (sel.sta_hi)   sta_hi_q   <= bus_wdata;
                if (sel.sta_lo)   sta_lo_q   <= bus_wdata;
            end
        end
    end

    assign tx_poll   = tx_poll_q;
    assign rx_poll   = rx_poll_q;
    assign tx_enable = control_q[CTRL_TX_BIT];
    assign rx_enable = control_q[CTRL_RX_BIT];
    assign irq       = |(status_q & int_en_q);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (1'b1)
                sel.version:  bus_rdata = VERSION_ID;
                sel.sta_hi:   bus_rdata = sta_hi_q;
                sel.sta_lo:   bus_rdata = sta_lo_q;
                sel.bus_mode: bus_rdata = bus_mode_q;
                sel.rx_base:  bus_rdata = ch_base_q[CH_RX];
                sel.tx_base:  bus_rdata = ch_base_q[CH_TX];
                sel.status:   bus_rdata = status_q;
                sel.control:  bus_rdata = control_q;
                sel.int_en:   bus_rdata = int_en_q;
                sel.cur_tx:   bus_rdata = ch_cur_q[CH_TX];
                sel.cur_rx:   bus_rdata = ch_cur_q[CH_RX];
                default:      bus_rdata = '0;
            endcase
        end
    end

    a_r7_tx_poll_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(bus_wr && sel.tx_poll));

    a_r7_rx_poll_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_poll |-> $past(bus_wr && sel.rx_poll));

    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_wr) || $past(|hw_status_set)));

    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_rdata == '0));

    a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    a_r5_busmode_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.bus_mode) |-> !bus_rdata[0]);

endmodule

// File: tb/dma_csr_bank_tb.sv
module dma_csr_bank_tb;
    localparam int CLK_P = 10;
    localparam logic [47:0] MAC = 48'hA1B2_C3D4_E5F6;

    localparam logic [11:0] A_VER = 12'h020, A_SHI = 12'h040, A_SLO = 12'h044;
    localparam logic [11:0] A_BUS = 12'hF00, A_TXP = 12'hF04, A_RXP = 12'hF08;
    localparam logic [11:0] A_RXB = 12'hF0C, A_TXB = 12'hF10, A_ST  = 12'hF14;
    localparam logic [11:0] A_CTL = 12'hF18, A_IEN = 12'hF1C, A_CTX = 12'hF48;
    localparam logic [11:0] A_CRX = 12'hF4C;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata, hw_status_set = '0;
    logic        tx_ptr_load = 1'b0, rx_ptr_load = 1'b0;
    logic [31:0] tx_ptr_value = '0, rx_ptr_value = '0;
    logic [31:0] cur_tx_desc, cur_rx_desc;
    logic        tx_enable, rx_enable, tx_poll, rx_poll, irq;

    always #(CLK_P/2) clk = ~clk;

    dma_csr_bank #(.ADDR_W(12), .STATION_MAC(MAC)) u_dut (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model
    logic [31:0] m_bus, m_rxb, m_txb, m_st, m_ctl, m_ien, m_ctx, m_crx, m_shi, m_slo;
    logic        m_txp, m_rxp;

    task automatic model_reset();
        m_bus = 0; m_rxb = 0; m_txb = 0; m_st = 0; m_ctl = 0; m_ien = 0;
        m_ctx = 0; m_crx = 0; m_txp = 0; m_rxp = 0;
        m_shi = {16'h0, MAC[47:32]}; m_slo = MAC[31:0];
    endtask

    function automatic logic [31:0] exp_read(logic [11:0] a);
        case (a[11:2])
            10'h008: return 32'h0000_1012;
            10'h010: return m_shi;
            10'h011: return m_slo;
            10'h3C0: return m_bus;
            10'h3C3: return m_rxb;
            10'h3C4: return m_txb;
            10'h3C5: return m_st;
            10'h3C6: return m_ctl;
            10'h3C7: return m_ien;
            10'h3D2: return m_ctx;
            10'h3D3: return m_crx;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model update for one clock step
    task automatic model_step(logic wr, logic [11:0] a, logic [31:0] wd, logic [31:0] set,
                              logic txl, logic [31:0] txv, logic rxl, logic [31:0] rxv);
        logic [9:0] idx = a[11:2];
        if (wr && idx == 10'h3C5) m_st = m_st & ~wd;
        m_st = m_st | set;
        if (txl) m_ctx = txv;
        if (rxl) m_crx = rxv;
        m_txp = wr && idx == 10'h3C1;
        m_rxp = wr && idx == 10'h3C2;
        if (wr) begin
            case (idx)
                10'h3C0: m_bus = {wd[31:1], 1'b0};
                10'h3C3: begin m_rxb = wd; m_crx = wd; end
                10'h3C4: begin m_txb = wd; m_ctx = wd; end
                10'h3C6: m_ctl = wd;
                10'h3C7: m_ien = wd;
                10'h3D2: m_ctx = wd;
                10'h3D3: m_crx = wd;
                10'h010: m_shi = wd;
                10'h011: m_slo = wd;
                default: ;
            endcase
        end
    endtask

    // drive one cycle (called at a negedge), then check outputs at the next negedge
    task automatic step(logic wr, logic [11:0] a, logic [31:0] wd, logic [31:0] set,
                        logic txl, logic [31:0] txv, logic rxl, logic [31:0] rxv);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; hw_status_set = set;
        tx_ptr_load = txl; tx_ptr_value = txv; rx_ptr_load = rxl; rx_ptr_value = rxv;
        @(negedge clk);
        model_step(wr, a, wd, set, txl, txv, rxl, rxv);
        bus_wr = 0; hw_status_set = 0; tx_ptr_load = 0; rx_ptr_load = 0;
        check("R8 irq", {31'h0, irq}, {31'h0, |(m_st & m_ien)});
        check("R6/R11 cur_tx", cur_tx_desc, m_ctx);
        check("R6/R11 cur_rx", cur_rx_desc, m_crx);
        check("R7 poll strobes", {30'h0, tx_poll, rx_poll}, {30'h0, m_txp, m_rxp});
        check("R9 enables", {30'h0, tx_enable, rx_enable}, {30'h0, m_ctl[13], m_ctl[1]});
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        step(1'b1, a, d, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic rd_check(string req, logic [11:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp_read(a));
        bus_rd = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [11:0] POOL [13] = '{A_VER, A_SHI, A_SLO, A_BUS, A_TXP, A_RXP,
                                          A_RXB, A_TXB, A_ST, A_CTL, A_IEN, A_CTX, A_CRX};

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq at reset", {31'h0, irq}, 32'h0);
        rd_check("R1 status reset", A_ST);
        rd_check("R1 station hi reset", A_SHI);
        rd_check("R1 station lo reset", A_SLO);
        rd_check("R1 cur tx reset", A_CTX);

        // R2 version fixed
        wr_reg(A_VER, 32'hDEAD_BEEF);
        rd_check("R2 version", A_VER);

        // R5 bus mode bit 0
        wr_reg(A_BUS, 32'hFFFF_FFFF);
        rd_check("R5 bus mode", A_BUS);

        // R6 base reload
        wr_reg(A_RXB, 32'h1000_0040);
        wr_reg(A_TXB, 32'h2000_0080);
        rd_check("R6 cur rx", A_CRX);
        rd_check("R6 cur tx", A_CTX);

        // R7 poll strobes, poll words read zero
        wr_reg(A_TXP, 32'h1);
        wr_reg(A_RXP, 32'h1);
        step(1'b0, 12'h0, 0, 0, 0, 0, 0, 0);
        rd_check("R7 tx poll reads 0", A_TXP);

        // R4/R3/R8: set, enable, clear
        step(1'b0, 12'h0, 0, 32'h0001_00C1, 0, 0, 0, 0);
        rd_check("R4 status set", A_ST);
        wr_reg(A_IEN, 32'h0000_0040);
        check("R8 irq on", {31'h0, irq}, 32'h1);
        wr_reg(A_ST, 32'h0000_0041);
        rd_check("R3 w1c", A_ST);
        check("R8 irq off", {31'h0, irq}, 32'h0);

        // R4 collision: set and clear same bit, set wins
        step(1'b1, A_ST, 32'h0001_0080, 32'h0000_0080, 0, 0, 0, 0);
        rd_check("R4 set beats clear", A_ST);

        // R11 collision: sw pointer write vs engine load
        step(1'b1, A_CTX, 32'h3333_0000, 0, 1'b1, 32'h4444_0000, 1'b1, 32'h5555_0000);
        rd_check("R11 sw wins tx", A_CTX);
        rd_check("R11 engine rx", A_CRX);
        step(1'b1, A_RXB, 32'h6666_0000, 0, 1'b0, 0, 1'b1, 32'h7777_0000);
        rd_check("R11 base wins rx", A_CRX);

        // R9 control
        wr_reg(A_CTL, 32'h0000_2002);

        // R10 unmapped
        wr_reg(12'h800, 32'hFFFF_FFFF);
        rd_check("R10 unmapped read", 12'h800);
        rd_check("R10 unmapped no side effect", A_CTL);

        // R12 rdata idle
        bus_addr = A_VER; #1;
        check("R12 rdata idle", bus_rdata, 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic        wr  = ($urandom % 3) != 0;
            logic [11:0] a   = ($urandom % 5 == 0) ? 12'($urandom) : POOL[$urandom % 13];
            logic [31:0] wd  = $urandom;
            logic [31:0] set = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            logic        txl = ($urandom % 4) == 0;
            logic        rxl = ($urandom % 4) == 0;
            logic [31:0] txv = $urandom;
            logic [31:0] rxv = $urandom;
            if (a == A_ST && ($urandom % 2 == 0)) set = set | wd;
            step(wr, a, wd, set, txl, txv, rxl, rxv);
            rd_check("R3/R4/R10 random readback", POOL[$urandom % 13]);
            if (i % 50 == 0) rd_check("R10 random unmapped", 12'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule